// File: doc/BRIEF.md
# Accumulator Stored-Program Processor

This block is a small multi-cycle processor in which program words and data words share one word-addressed memory. Every access, whether it fetches an instruction or moves an operand, goes out through a memory address register. The returned word comes back through a memory data register. The result of each load or add ends up in a single accumulator. A word means nothing until it has been fetched and decoded. A value that a store writes can therefore be executed later as an instruction.

Each instruction runs a fixed sequence of register transfers. Fetch copies the program counter into the address register, waits one cycle for the synchronous memory, latches the word into the data register and steps the program counter. Decode then picks one of load, add, store, jump or halt. The memory port is a plain synchronous port with no back-pressure. The memory must return read data exactly one cycle after it samples the address, and it must accept a write in the cycle the strobe is high. Both the halted flag and the accumulator value are plain observation outputs.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator and the memory address and data registers clear to zero, `halted` and `mem_we` are low, and the program counter is set to 1. After `rst` falls, the first fetch reads address 1, and a reset taken partway through a program restarts it from the same state.
- R2: The second cycle of every instruction drives the program counter value on `mem_addr`. The program counter then advances by one, modulo 32, so instructions that are not jumps are fetched from consecutive addresses.
- R3: An instruction word is 8 bits. Bits [7:5] hold the opcode and bits [4:0] hold the operand address A. The opcode values are 001 load, 010 add, 011 store, 100 jump and 000 halt.
- R4: A load takes 7 cycles and drives A on `mem_addr` in its 5th cycle. From the cycle after the 7th, the accumulator holds the memory word at A.
- R5: An add has the same timing as a load. It replaces the accumulator with the accumulator plus the word at A, modulo 256, with no flags.
- R6: A store takes 5 cycles. In its 5th cycle, and in no other cycle, `mem_we` is high, `mem_addr` is A and `mem_wdata` equals the accumulator. The memory word at A is overwritten.
- R7: A jump takes 4 cycles, and the next fetch reads address A.
- R8: Opcode 000 and the undefined opcodes 101, 110 and 111 halt. After the 4 cycles of the halting instruction, `halted` goes high and stays high until reset. From then on `mem_we` stays low, and both the accumulator and `mem_addr` stay constant.
- R9: A word written by a store and later reached by the program counter executes as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 5 | Memory address, driven from the address register |
| mem_wdata | output | 8 | Write data, driven from the data register |
| mem_we | output | 1 | Write strobe for one cycle of a store |
| mem_rdata | input | 8 | Read data, valid one cycle after the address is sampled |
| halted | output | 1 | High once a halting opcode has been executed |
| acc_value | output | 8 | Current accumulator contents |

## Verification
The results fall due at fixed cycles, counted from the first cycle of each instruction:
- The fetch address appears in cycle 2.
- A load or add operand address appears in cycle 5.
- The new accumulator value becomes visible in cycle 8.
- The write strobe of a store comes in cycle 5.
- `halted` rises in cycle 5 of a halting instruction.

A behavioural instruction-level model in the bench turns each instruction it interprets into one expectation per clock, with these offsets, and pushes them into queues. The queues are popped and compared against the ports on every falling edge from the cycle reset is released. Fields that carry no meaning in a given cycle are marked don't-care. After each program the bench compares the whole memory image with the model's copy.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 3;

  localparam logic [OPC_W-1:0] OP_HALT  = 3'b000;
  localparam logic [OPC_W-1:0] OP_LOAD  = 3'b001;
  localparam logic [OPC_W-1:0] OP_ADD   = 3'b010;
  localparam logic [OPC_W-1:0] OP_STORE = 3'b011;
  localparam logic [OPC_W-1:0] OP_JUMP  = 3'b100;

  typedef enum logic [3:0] {
    PH_FETCH_ADDR,
    PH_FETCH_WAIT,
    PH_FETCH_LATCH,
    PH_DECODE,
    PH_OPND_WAIT,
    PH_OPND_LATCH,
    PH_EXECUTE,
    PH_WRITE,
    PH_STOPPED
  } phase_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mdr_from_mem;
    logic mdr_from_acc;
    logic pc_step;
    logic pc_jump;
    logic acc_load;
    logic acc_sum;
    logic mem_write;
  } xfer_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int WORD_W = 8
) (
  input  logic [WORD_W-1:0] lhs,
  input  logic [WORD_W-1:0] rhs,
  output logic [WORD_W-1:0] sum
);
  // wraps modulo 2**WORD_W, carry discarded
  always_comb sum = lhs + rhs;
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] ir_opc,
  output xfer_t            xfer,
  output logic             halted_o
);

  phase_e           ph_q, ph_d;
  logic [OPC_W-1:0] op_q;

  always_comb begin
    ph_d = ph_q;
    xfer = '0;
    case (ph_q)
      PH_FETCH_ADDR: begin
        xfer.mar_from_pc = 1'b1;
        ph_d = PH_FETCH_WAIT;
      end
      PH_FETCH_WAIT: ph_d = PH_FETCH_LATCH;
      PH_FETCH_LATCH: begin
        xfer.mdr_from_mem = 1'b1;
        xfer.pc_step      = 1'b1;
        ph_d = PH_DECODE;
      end
      PH_DECODE: begin
        case (ir_opc)
          OP_LOAD, OP_ADD: begin
            xfer.mar_from_ir = 1'b1;
            ph_d = PH_OPND_WAIT;
          end
          OP_STORE: begin
            xfer.mar_from_ir  = 1'b1;
            xfer.mdr_from_acc = 1'b1;
            ph_d = PH_WRITE;
          end
          OP_JUMP: begin
            xfer.pc_jump = 1'b1;
            ph_d = PH_FETCH_ADDR;
          end
          default: ph_d = PH_STOPPED;
        endcase
      end
      PH_OPND_WAIT: ph_d = PH_OPND_LATCH;
      PH_OPND_LATCH: begin
        xfer.mdr_from_mem = 1'b1;
        ph_d = PH_EXECUTE;
      end
      PH_EXECUTE: begin
        if (op_q == OP_ADD) xfer.acc_sum  = 1'b1;
        else                xfer.acc_load = 1'b1;
        ph_d = PH_FETCH_ADDR;
      end
      PH_WRITE: begin
        xfer.mem_write = 1'b1;
        ph_d = PH_FETCH_ADDR;
      end
      default: ph_d = PH_STOPPED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_FETCH_ADDR;
      op_q <= OP_HALT;
    end else begin
      ph_q <= ph_d;
      if (ph_q == PH_DECODE) op_q <= ir_opc;
    end
  end

  assign halted_o = (ph_q == PH_STOPPED);

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> halted_o);

endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_cpu_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int ADDR_W = WORD_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  xfer_t             xfer,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mar_o,
  output logic [WORD_W-1:0] mdr_o,
  output logic [WORD_W-1:0] acc_o,
  output logic [OPC_W-1:0]  ir_opc
);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [WORD_W-1:0] mdr_q, acc_q, sum_w;
  logic [ADDR_W-1:0] operand_w;

  assign operand_w = mdr_q[ADDR_W-1:0];

  acc_alu #(.WORD_W(WORD_W)) u_alu (
    .lhs(acc_q),
    .rhs(mdr_q),
    .sum(sum_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= ADDR_W'(1);
      mar_q <= '0;
      mdr_q <= '0;
      acc_q <= '0;
    end else begin
      if (xfer.pc_jump)      pc_q <= operand_w;
      else if (xfer.pc_step) pc_q <= pc_q + 1'b1;

      if (xfer.mar_from_pc)      mar_q <= pc_q;
      else if (xfer.mar_from_ir) mar_q <= operand_w;

      if (xfer.mdr_from_mem)      mdr_q <= mem_rdata;
      else if (xfer.mdr_from_acc) mdr_q <= acc_q;

      if (xfer.acc_load)     acc_q <= mdr_q;
      else if (xfer.acc_sum) acc_q <= sum_w;
    end
  end

  assign mar_o  = mar_q;
  assign mdr_o  = mdr_q;
  assign acc_o  = acc_q;
  assign ir_opc = mdr_q[WORD_W-1 -: OPC_W];

  // R2
  pc_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    xfer.pc_step |=> pc_q == ADDR_W'($past(mar_q) + 1'b1));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int ADDR_W = WORD_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              halted,
  output logic [WORD_W-1:0] acc_value
);

  xfer_t            xfer;
  logic [OPC_W-1:0] ir_opc;

  acc_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .ir_opc   (ir_opc),
    .xfer     (xfer),
    .halted_o (halted)
  );

  acc_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .xfer      (xfer),
    .mem_rdata (mem_rdata),
    .mar_o     (mem_addr),
    .mdr_o     (mem_wdata),
    .acc_o     (acc_value),
    .ir_opc    (ir_opc)
  );

  assign mem_we = xfer.mem_write;

  // R6
  store_data_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata == acc_value);

  // R6
  write_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (!mem_we && $stable(acc_value) && $stable(mem_addr)));

endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  import acc_cpu_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 8;
  localparam int ADDR_W = WORD_W - OPC_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WMASK  = (1 << WORD_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_wdata;
  logic              mem_we;
  logic [WORD_W-1:0] mem_rdata = '0;
  logic              halted;
  logic [WORD_W-1:0] acc_value;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  acc_cpu #(.WORD_W(WORD_W)) dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted), .acc_value(acc_value)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // synchronous memory, one cycle read latency
  logic [WORD_W-1:0] ram [DEPTH];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  // expectation queues, one entry per clock
  int    q_acc[$], q_halt[$], q_we[$], q_addr[$], q_wd[$];
  string q_tag[$];
  int    iss_mem[DEPTH];

  function automatic int enc(int op, int a);
    return ((op & 7) << ADDR_W) | (a & (DEPTH - 1));
  endfunction

  task automatic push(int a, int h, int w, int ad, int wd, string tag);
    q_acc.push_back(a); q_halt.push_back(h); q_we.push_back(w);
    q_addr.push_back(ad); q_wd.push_back(wd); q_tag.push_back(tag);
  endtask

  task automatic clear_q();
    q_acc.delete(); q_halt.delete(); q_we.delete();
    q_addr.delete(); q_wd.delete(); q_tag.delete();
  endtask

  task automatic clear_ram();
    for (int i = 0; i < DEPTH; i++) ram[i] = '0;
  endtask

  // instruction-level model producing per-cycle expectations
  task automatic build_trace();
    int pc, acc, steps;
    bit done;
    string ftag;
    pc = 1; acc = 0; done = 0; steps = 0; ftag = "R1";
    for (int i = 0; i < DEPTH; i++) iss_mem[i] = int'(ram[i]);
    while (!done && steps < 200) begin
      int word, op, a, fpc;
      word = iss_mem[pc];
      op = (word >> ADDR_W) & 7;
      a = word & (DEPTH - 1);
      fpc = pc;
      pc = (pc + 1) % DEPTH;
      push(acc, 0, 0, -1, 0, "R2");
      push(acc, 0, 0, fpc, 0, ftag);
      push(acc, 0, 0, -1, 0, "R2");
      push(acc, 0, 0, -1, 0, "R3");
      ftag = "R2";
      case (op)
        1: begin
          push(acc, 0, 0, a, 0, "R4");
          push(acc, 0, 0, -1, 0, "R4");
          push(acc, 0, 0, -1, 0, "R4");
          acc = iss_mem[a];
        end
        2: begin
          push(acc, 0, 0, a, 0, "R5");
          push(acc, 0, 0, -1, 0, "R5");
          push(acc, 0, 0, -1, 0, "R5");
          acc = (acc + iss_mem[a]) & WMASK;
        end
        3: begin
          push(acc, 0, 1, a, acc, "R6");
          iss_mem[a] = acc;
        end
        4: begin
          pc = a;
          ftag = "R7";
        end
        default: done = 1;
      endcase
      steps++;
    end
    for (int i = 0; i < 6; i++) push(acc, 1, 0, -1, 0, "R8");
  endtask

  task automatic compare_pop();
    int ea, eh, ew, ead, ewd;
    string tg;
    bit bad;
    ea = q_acc.pop_front(); eh = q_halt.pop_front(); ew = q_we.pop_front();
    ead = q_addr.pop_front(); ewd = q_wd.pop_front(); tg = q_tag.pop_front();
    bad = (int'(acc_value) != ea) || (int'(halted) != eh) || (int'(mem_we) != ew)
       || (ead >= 0 && int'(mem_addr) != ead)
       || (ew == 1 && int'(mem_wdata) != ewd);
    n_cmp++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s t=%0t acc=%0d/%0d halted=%0d/%0d we=%0d/%0d addr=%0d/%0d wdata=%0d/%0d (actual/expected)",
               tg, $time, acc_value, ea, halted, eh, mem_we, ew, mem_addr, ead, mem_wdata, ewd);
    end
  endtask

  task automatic check_int(string tg, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tg, act, exp);
    end
  endtask

  // ram already loaded; cycle_limit cuts the run short to test mid-run reset
  task automatic run_program(int cycle_limit, string mem_tag);
    int cnt;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check_int("R1 acc", int'(acc_value), 0);
    check_int("R1 halted", int'(halted), 0);
    check_int("R1 we", int'(mem_we), 0);
    check_int("R1 mar", int'(mem_addr), 0);
    check_int("R1 mdr", int'(mem_wdata), 0);
    clear_q();
    build_trace();
    rst = 1'b0;
    cnt = 0;
    while (q_acc.size() > 0 && cnt < cycle_limit) begin
      compare_pop();
      cnt++;
      @(negedge clk);
    end
    if (q_acc.size() == 0) begin
      for (int i = 0; i < DEPTH; i++)
        check_int(mem_tag, int'(ram[i]), iss_mem[i]);
    end
    clear_q();
  endtask

  initial begin
    // P2 cut short then rerun: R1 mid-run reset; R7 jump, R5 wrap, R8 undefined 111
    clear_ram();
    ram[1] = WORD_W'(enc(1, 20));
    ram[2] = WORD_W'(enc(2, 21));
    ram[3] = WORD_W'(enc(3, 22));
    ram[4] = WORD_W'(enc(4, 10));
    ram[5] = WORD_W'(enc(3, 0));   // skipped by the jump
    ram[10] = WORD_W'(enc(2, 22));
    ram[11] = WORD_W'(enc(3, 23));
    ram[12] = WORD_W'(enc(7, 0));  // undefined opcode halts
    ram[13] = WORD_W'(enc(3, 1));  // must never run
    ram[20] = 8'd200;
    ram[21] = 8'd100;
    run_program(12, "R1");
    run_program(100000, "R7");
    check_int("R5 wrap sum", int'(ram[22]), 44);
    check_int("R6 second store", int'(ram[23]), 88);
    check_int("R8 no store after halt", int'(ram[1]), enc(1, 20));

    // P1: load, add, store, halt
    clear_ram();
    ram[1] = WORD_W'(enc(1, 5));
    ram[2] = WORD_W'(enc(2, 6));
    ram[3] = WORD_W'(enc(3, 6));
    ram[4] = WORD_W'(enc(0, 0));
    ram[5] = 8'd23;
    ram[6] = 8'd12;
    run_program(100000, "R6");
    check_int("R5 acc", int'(acc_value), 35);
    check_int("R6 mem6", int'(ram[6]), 35);

    // P3: R9 stored word executes as instruction; undefined 101 halts
    clear_ram();
    ram[1] = WORD_W'(enc(1, 30));
    ram[2] = WORD_W'(enc(3, 12));
    ram[3] = WORD_W'(enc(4, 12));
    ram[12] = WORD_W'(enc(4, 12));  // self-loop unless overwritten
    ram[13] = WORD_W'(enc(5, 0));
    ram[28] = 8'd77;
    ram[30] = WORD_W'(enc(1, 28));
    run_program(100000, "R9");
    check_int("R9 acc", int'(acc_value), 77);
    check_int("R8 halted", int'(halted), 1);

    // P4: R5 repeated add wraps; undefined 110 halts
    clear_ram();
    ram[1] = WORD_W'(enc(2, 31));
    ram[2] = WORD_W'(enc(2, 31));
    ram[3] = WORD_W'(enc(6, 0));
    ram[31] = 8'd255;
    run_program(100000, "R5");
    check_int("R5 acc wrap", int'(acc_value), 254);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule